// File: doc/BRIEF.md
# Bus Transaction Beat Sequencer

This block turns one pending memory access into a system bus transaction made of one, two or four data beats. It takes in the request's address, byte size, kind and memory attributes, the data cache enable and lock state, and a bus mode select. From these it chooses the beat plan. It then presents one beat at a time: the beat address, the byte size and the burst indicator. It moves to the next beat each time the bus acknowledges the current one.

Cacheable misses fill a whole 32-byte block. The fill starts at the double word that holds the missing access and wraps around inside the block, so the critical data arrives first. Castouts and other block moves run in ascending order from the block base. Uncached and write-through accesses travel as single beats that may be misaligned. A 128-bit vector access that bypasses the cache becomes a two-beat burst in the extended bus mode. In the legacy mode it is split into two plain 8-byte beats. The block accepts a request only while it is idle and latches the request fields at that moment. It pulses `done` once the last beat has been acknowledged.

Top module: `bus_beat_seq`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `req_ready` is 1 and both `beat_valid` and `done` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. Its fields are captured at that edge. While a transaction is in progress, `req_ready` is 0, and changes on `req_valid` or on any request field leave the beats that are being presented unchanged.
- R3: For kind 3 (scalar), when attribute bit 3 (write-through) or bit 2 (caching-inhibited) is set, or when `cache_en` is 0, or when `cache_lock` is 1, the transaction is one beat. That beat carries the request address unaltered, misaligned if it is so, and the request size (1 to 8 bytes), with `beat_burst` low.
- R4: Attribute bit 1 (coherent) and bit 0 (guarded) have no influence on the number of beats, their addresses or their sizes.
- R5: Kind 0 (block fill) always moves four beats. So do a cacheable scalar or vector access (neither bit 3 nor bit 2 set, cache enabled and unlocked). Each beat is 8 bytes. With s = address bits [4:3], the beats go to double words s, s+1, s+2 and s+3 modulo 4 inside the 32-byte block.
- R6: Kind 1 (castout or other block transfer) moves four 8-byte beats to double words 0, 1, 2 and 3 of the 32-byte-aligned block, in that order.
- R7: Kind 2 (vector) that is not cacheable in the sense of R5 becomes, when `bus_mode_ext` is 1, a two-beat 8-byte burst to the 16-byte-aligned base and then base+8.
- R8: The same vector access with `bus_mode_ext` 0 becomes two 8-byte beats to the 16-byte base and base+8, with `beat_burst` low on both.
- R9: `beat_burst` is high on every beat of a two- or four-beat burst. Every burst beat has size 8 and a double-word-aligned address.
- R10: A beat stays on the outputs, unchanged, until `beat_ack` is 1 at a clock edge. `beat_num` starts at 0 and rises by one per acknowledged beat. `beat_ack` is ignored while idle.
- R11: `done` is 1 for exactly the one cycle after the edge that acknowledges the final beat. The block is idle and ready in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | clog2(BEAT_BYTES)+1 | Byte count for single-beat accesses |
| req_attr | input | 4 | Bit 3 write-through, bit 2 caching-inhibited, bit 1 coherent, bit 0 guarded |
| req_kind | input | 2 | 0 block fill, 1 castout/other block, 2 vector, 3 scalar |
| cache_en | input | 1 | Data cache enabled |
| cache_lock | input | 1 | Data cache locked |
| bus_mode_ext | input | 1 | 1 extended bus mode, 0 legacy mode |
| beat_ack | input | 1 | Current beat accepted by the bus |
| beat_valid | output | 1 | A beat is being presented |
| beat_addr | output | ADDR_W | Address of the current beat |
| beat_size | output | clog2(BEAT_BYTES)+1 | Byte size of the current beat |
| beat_burst | output | 1 | Transaction is a burst |
| beat_num | output | clog2(BLOCK_BEATS) | Index of the current beat |
| done | output | 1 | One-cycle pulse after the final beat is acknowledged |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 8-byte beats, 4-beat blocks and 2-beat vector bursts. With these values every wrap start point of the critical-first order can be reached, as can the partial-field case of the vector burst, where only address bit 3 steps and bit 4 is kept. A behavioural model builds the expected beat list for each request and checks it on every clock. Runs use gapped acknowledges, stray acknowledges while idle, and request fields that change during a transaction.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

   typedef enum logic [1:0] {
      KIND_FILL   = 2'd0,
      KIND_BLOCK  = 2'd1,
      KIND_VEC    = 2'd2,
      KIND_SCALAR = 2'd3
   } req_kind_e;

   localparam int ATTR_WT = 3;
   localparam int ATTR_CI = 2;

endpackage

// File: rtl/bbs_classify.sv
module bbs_classify
   import bbs_pkg::*;
#(
   parameter int BLK_LOG = 2,
   parameter int VEC_LOG = 1
) (
   input  req_kind_e            kind,
   input  logic [3:0]           attr,
   input  logic                 cache_en,
   input  logic                 cache_lock,
   input  logic                 mode_ext,
   output logic [BLK_LOG-1:0]   beat_mask,
   output logic                 wrap,
   output logic                 burst,
   output logic                 raw
);
   localparam logic [BLK_LOG-1:0] BLK_MASK = '1;
   localparam logic [BLK_LOG-1:0] VEC_MASK = BLK_LOG'((1 << VEC_LOG) - 1);

   logic bypass;
   logic attr_unused;

   assign bypass      = attr[ATTR_WT] | attr[ATTR_CI] | ~cache_en | cache_lock;
   assign attr_unused = ^attr[1:0];

   always_comb begin
      beat_mask = BLK_MASK;
      wrap      = 1'b1;
      burst     = 1'b1;
      raw       = 1'b0;
      unique case (kind)
         KIND_BLOCK: wrap = 1'b0;
         KIND_VEC: begin
            if (bypass) begin
               beat_mask = VEC_MASK;
               wrap      = 1'b0;
               burst     = mode_ext;
            end
         end
         KIND_SCALAR: begin
            if (bypass) begin
               beat_mask = '0;
               wrap      = 1'b0;
               burst     = 1'b0;
               raw       = 1'b1;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/bbs_addr_gen.sv
module bbs_addr_gen #(
   parameter int ADDR_W  = 32,
   parameter int OFF_W   = 3,
   parameter int BLK_LOG = 2
) (
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [BLK_LOG-1:0] idx,
   input  logic [BLK_LOG-1:0] beat_mask,
   input  logic               wrap,
   input  logic               raw,
   output logic [ADDR_W-1:0]  addr
);
   localparam int HI_LSB = OFF_W + BLK_LOG;

   logic [BLK_LOG-1:0] start;
   logic [BLK_LOG-1:0] sum;
   logic [BLK_LOG-1:0] dw_field;
   logic [ADDR_W-1:0]  aligned;

   assign start = wrap ? base_addr[OFF_W +: BLK_LOG] : '0;
   assign sum   = start + idx;

   // Each double-word index bit steps only inside the burst region;
   // bits above the region keep the request address.
   for (genvar i = 0; i < BLK_LOG; i++) begin : g_dw_bit
      assign dw_field[i] = beat_mask[i] ? sum[i] : base_addr[OFF_W + i];
   end

   assign aligned = {base_addr[ADDR_W-1:HI_LSB], dw_field, {OFF_W{1'b0}}};
   assign addr    = raw ? base_addr : aligned;

endmodule

// File: rtl/bus_beat_seq.sv
module bus_beat_seq
   import bbs_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BEAT_BYTES  = 8,
   parameter int BLOCK_BEATS = 4,
   parameter int VEC_BEATS   = 2
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [ADDR_W-1:0]               req_addr,
   input  logic [$clog2(BEAT_BYTES):0]     req_size,
   input  logic [3:0]                      req_attr,
   input  logic [1:0]                      req_kind,
   input  logic                            cache_en,
   input  logic                            cache_lock,
   input  logic                            bus_mode_ext,
   input  logic                            beat_ack,
   output logic                            beat_valid,
   output logic [ADDR_W-1:0]               beat_addr,
   output logic [$clog2(BEAT_BYTES):0]     beat_size,
   output logic                            beat_burst,
   output logic [$clog2(BLOCK_BEATS)-1:0]  beat_num,
   output logic                            done
);
   localparam int OFF_W   = $clog2(BEAT_BYTES);
   localparam int SIZE_W  = OFF_W + 1;
   localparam int BLK_LOG = $clog2(BLOCK_BEATS);
   localparam int VEC_LOG = $clog2(VEC_BEATS);

   if (BEAT_BYTES < 2 || (1 << OFF_W) != BEAT_BYTES) begin : g_chk_beat
      $error("BEAT_BYTES must be a power of two of at least 2");
   end
   if (BLOCK_BEATS < 2 || (1 << BLK_LOG) != BLOCK_BEATS) begin : g_chk_blk
      $error("BLOCK_BEATS must be a power of two of at least 2");
   end
   if (VEC_BEATS < 2 || (1 << VEC_LOG) != VEC_BEATS || VEC_BEATS > BLOCK_BEATS) begin : g_chk_vec
      $error("VEC_BEATS must be a power of two between 2 and BLOCK_BEATS");
   end
   if (ADDR_W <= OFF_W + BLK_LOG) begin : g_chk_addr
      $error("ADDR_W too narrow for the block size");
   end

   logic [BLK_LOG-1:0] c_mask;
   logic               c_wrap;
   logic               c_burst;
   logic               c_raw;

   bbs_classify #(
      .BLK_LOG (BLK_LOG),
      .VEC_LOG (VEC_LOG)
   ) u_classify (
      .kind       (req_kind_e'(req_kind)),
      .attr       (req_attr),
      .cache_en   (cache_en),
      .cache_lock (cache_lock),
      .mode_ext   (bus_mode_ext),
      .beat_mask  (c_mask),
      .wrap       (c_wrap),
      .burst      (c_burst),
      .raw        (c_raw)
   );

   logic               busy;
   logic               done_q;
   logic [ADDR_W-1:0]  l_addr;
   logic [SIZE_W-1:0]  l_size;
   logic [BLK_LOG-1:0] l_mask;
   logic               l_wrap;
   logic               l_burst;
   logic               l_raw;
   logic [BLK_LOG-1:0] idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         done_q  <= 1'b0;
         l_addr  <= '0;
         l_size  <= '0;
         l_mask  <= '0;
         l_wrap  <= 1'b0;
         l_burst <= 1'b0;
         l_raw   <= 1'b0;
         idx     <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy) begin
            if (req_valid) begin
               busy    <= 1'b1;
               idx     <= '0;
               l_addr  <= req_addr;
               l_size  <= req_size;
               l_mask  <= c_mask;
               l_wrap  <= c_wrap;
               l_burst <= c_burst;
               l_raw   <= c_raw;
            end
         end else if (beat_ack) begin
            if (idx == l_mask) begin
               busy   <= 1'b0;
               done_q <= 1'b1;
            end else begin
               idx <= idx + 1'b1;
            end
         end
      end
   end

   bbs_addr_gen #(
      .ADDR_W  (ADDR_W),
      .OFF_W   (OFF_W),
      .BLK_LOG (BLK_LOG)
   ) u_addr_gen (
      .base_addr (l_addr),
      .idx       (idx),
      .beat_mask (l_mask),
      .wrap      (l_wrap),
      .raw       (l_raw),
      .addr      (beat_addr)
   );

   assign req_ready  = ~busy;
   assign beat_valid = busy;
   assign beat_size  = l_raw ? l_size : SIZE_W'(BEAT_BYTES);
   assign beat_burst = l_burst;
   assign beat_num   = idx;
   assign done       = done_q;

endmodule

// File: rtl/bbs_checker.sv
module bbs_checker #(
   parameter int ADDR_W      = 32,
   parameter int BEAT_BYTES  = 8,
   parameter int BLOCK_BEATS = 4,
   parameter int VEC_BEATS   = 2
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic                            req_valid,
   input logic                            req_ready,
   input logic                            beat_ack,
   input logic                            beat_valid,
   input logic [ADDR_W-1:0]               beat_addr,
   input logic [$clog2(BEAT_BYTES):0]     beat_size,
   input logic                            beat_burst,
   input logic [$clog2(BLOCK_BEATS)-1:0]  beat_num,
   input logic                            done
);
   localparam int OFF_W  = $clog2(BEAT_BYTES);
   localparam int HI_LSB = OFF_W + $clog2(BLOCK_BEATS);
   localparam int VEC_OK = VEC_BEATS;

   assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> beat_valid)
      else $error("request taken while idle did not start a beat");

   assert_burst_shape_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_burst) |->
         (beat_addr[OFF_W-1:0] == '0 && beat_size == ($clog2(BEAT_BYTES)+1)'(BEAT_BYTES)))
      else $error("burst beat misaligned or not full width");

   assert_same_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && beat_ack && beat_burst) |=>
         (!beat_valid || beat_addr[ADDR_W-1:HI_LSB] == $past(beat_addr[ADDR_W-1:HI_LSB])))
      else $error("burst left its block");

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (beat_valid && !beat_ack) |=>
         (beat_valid && $stable(beat_addr) && $stable(beat_num) && $stable(beat_burst)))
      else $error("beat changed without acknowledge");

   assert_first_num_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(beat_valid) |-> (beat_num == '0))
      else $error("transaction did not start at beat 0");

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!beat_valid && req_ready && $past(beat_valid && beat_ack)))
      else $error("done without a final acknowledge");

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done held longer than one cycle");

   initial begin
      assert (VEC_OK >= 2) else $error("vector burst too short");
   end

endmodule

bind bus_beat_seq bbs_checker #(
   .ADDR_W      (ADDR_W),
   .BEAT_BYTES  (BEAT_BYTES),
   .BLOCK_BEATS (BLOCK_BEATS),
   .VEC_BEATS   (VEC_BEATS)
) u_chk (.*);

// File: tb/bus_beat_seq_tb.sv
module bus_beat_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_size = '0;
   logic [3:0]  req_attr = '0;
   logic [1:0]  req_kind = '0;
   logic        cache_en = 1'b1;
   logic        cache_lock = 1'b0;
   logic        bus_mode_ext = 1'b1;
   logic        beat_ack = 1'b0;
   logic        beat_valid;
   logic [31:0] beat_addr;
   logic [3:0]  beat_size;
   logic        beat_burst;
   logic [1:0]  beat_num;
   logic        done;

   always #5 clk = ~clk;

   bus_beat_seq u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ready    (req_ready),
      .req_addr     (req_addr),
      .req_size     (req_size),
      .req_attr     (req_attr),
      .req_kind     (req_kind),
      .cache_en     (cache_en),
      .cache_lock   (cache_lock),
      .bus_mode_ext (bus_mode_ext),
      .beat_ack     (beat_ack),
      .beat_valid   (beat_valid),
      .beat_addr    (beat_addr),
      .beat_size    (beat_size),
      .beat_burst   (beat_burst),
      .beat_num     (beat_num),
      .done         (done)
   );

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [31:0] qa[$];
   int          qs[$];
   bit          qb[$];
   bit          m_busy = 0;
   bit          m_done = 0;
   int          m_num  = 0;
   string       tag    = "R1";

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      chk("R2", "req_ready", req_ready, !m_busy);
      chk("R10", "beat_valid", beat_valid, m_busy);
      chk("R11", "done", done, m_done);
      if (m_busy) begin
         chk(tag, "beat_addr", beat_addr, qa[0]);
         chk(tag, "beat_size", beat_size, qs[0]);
         chk("R9", "beat_burst", beat_burst, qb[0]);
         chk("R10", "beat_num", beat_num, m_num);
      end
   endtask

   // Expected beat list from the requirements
   task automatic build();
      bit bypass;
      logic [31:0] base;
      int s;
      bypass = req_attr[3] | req_attr[2] | !cache_en | cache_lock;
      qa.delete(); qs.delete(); qb.delete();
      if (req_kind == 2'd1) begin
         base = req_addr & ~32'h1F;
         for (int k = 0; k < 4; k++) begin qa.push_back(base + 32'(k*8)); qs.push_back(8); qb.push_back(1); end
      end else if (req_kind == 2'd2 && bypass) begin
         base = req_addr & ~32'hF;
         for (int k = 0; k < 2; k++) begin qa.push_back(base + 32'(k*8)); qs.push_back(8); qb.push_back(bus_mode_ext); end
      end else if (req_kind == 2'd3 && bypass) begin
         qa.push_back(req_addr); qs.push_back(int'(req_size)); qb.push_back(0);
      end else begin
         base = req_addr & ~32'h1F;
         s = int'(req_addr[4:3]);
         for (int k = 0; k < 4; k++) begin qa.push_back(base + 32'(((s + k) % 4) * 8)); qs.push_back(8); qb.push_back(1); end
      end
   endtask

   task automatic cyc(input bit rv, input bit ack);
      bit nd;
      req_valid = rv;
      beat_ack  = ack;
      @(posedge clk);
      nd = 0;
      if (!m_busy) begin
         if (rv) begin build(); m_busy = 1; m_num = 0; end
      end else if (ack) begin
         void'(qa.pop_front()); void'(qs.pop_front()); void'(qb.pop_front());
         m_num++;
         if (qa.size() == 0) begin m_busy = 0; nd = 1; end
      end
      m_done = nd;
      @(negedge clk);
      compare();
   endtask

   task automatic run(input string t, input logic [1:0] kind, input logic [31:0] addr,
                      input logic [3:0] size, input logic [3:0] attr, input bit en,
                      input bit lock, input bit mode, input int gap, input bit disturb);
      tag = t;
      req_kind = kind; req_addr = addr; req_size = size; req_attr = attr;
      cache_en = en; cache_lock = lock; bus_mode_ext = mode;
      cyc(1, 0);
      while (m_busy) begin
         for (int g = 0; g < gap; g++) begin
            if (disturb) begin
               req_kind = 2'(g + 1); req_addr = ~addr; req_size = 4'd2;
               req_attr = 4'b0100; bus_mode_ext = ~mode;
            end
            cyc(disturb, 0);
         end
         cyc(disturb, 1);
      end
      cyc(0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      tag = "R1";
      chk("R1", "ready in reset", req_ready, 1);
      chk("R1", "valid in reset", beat_valid, 0);
      chk("R1", "done in reset", done, 0);
      rst_n = 1'b1;
      cyc(0, 0);
      cyc(0, 1);                                                          // R10 stray ack while idle
      run("R3", 2'd3, 32'h0000_1005, 4'd3, 4'b1000, 1, 0, 1, 0, 0);      // write-through, misaligned
      run("R3", 2'd3, 32'h0000_2003, 4'd8, 4'b0100, 1, 0, 0, 1, 0);      // caching-inhibited
      run("R3", 2'd3, 32'h0000_3001, 4'd1, 4'b0000, 0, 0, 1, 0, 0);      // cache disabled
      run("R3", 2'd3, 32'h0000_3106, 4'd2, 4'b0000, 1, 1, 1, 0, 0);      // cache locked
      run("R4", 2'd3, 32'h0000_4057, 4'd4, 4'b0011, 1, 0, 1, 0, 0);      // coherent+guarded, critical dw 2
      run("R5", 2'd0, 32'h0000_5018, 4'd8, 4'b0000, 1, 0, 1, 2, 0);      // fill from dw 3, gapped acks
      run("R5", 2'd0, 32'h0000_6000, 4'd8, 4'b0010, 1, 0, 0, 0, 0);      // fill from dw 0
      run("R5", 2'd2, 32'h0000_6A2C, 4'd8, 4'b0000, 1, 0, 1, 1, 0);      // cacheable vector fill, dw 1
      run("R6", 2'd1, 32'h0000_707C, 4'd8, 4'b0000, 1, 0, 1, 1, 0);      // castout in order
      run("R7", 2'd2, 32'h0000_8038, 4'd8, 4'b1000, 1, 0, 1, 0, 0);      // vector burst, extended mode
      run("R7", 2'd2, 32'h0000_8107, 4'd8, 4'b0000, 0, 0, 1, 1, 0);      // vector, cache off
      run("R8", 2'd2, 32'h0000_9044, 4'd8, 4'b0100, 1, 0, 0, 1, 0);      // vector split, legacy mode
      run("R2", 2'd0, 32'h0000_A010, 4'd8, 4'b0000, 1, 0, 1, 2, 1);      // request fields churn while busy
      cyc(0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule